// File: doc/BRIEF.md
# Fixed-Point PID Compensator

This block is the compensator of a switching power converter's voltage loop. Once per switching period a one-cycle enable tick arrives from the system-clock domain together with a signed fractional error sample. The block registers the sample and keeps the sample of the previous tick. It then forms the proportional, integral and derivative contributions in parallel with three constant-gain multiplies, and drives a signed fractional control word for a PWM modulator.

All arithmetic is two's complement fixed point. The error is Q1.9 and the gains are Q3.10. Products and sums live in a Q4.19 working format. Two separate saturation stages act on the result. The integral accumulator is clamped so that it cannot wind up. The final sum is clamped to the span of the output format and then truncated to Q1.11. Between ticks the output word holds its value.

Top module: `pid_comp`

## Requirements
- R1: While `rst_n` is low, `ctrl_out` is 0. Reset also clears the integral accumulator and the stored previous error to 0, so the first update after reset acts as if the earlier error and the earlier integral were both zero.
- R2: A tick sampled high at clock edge k updates `ctrl_out` at edge k+1. At every other edge `ctrl_out` keeps its value. Ticks are at least two cycles apart.
- R3: The proportional term is KP·e in Q4.19, where e is `err_in` read as a signed Q1.9 value (bit 9 is the sign and 9 fractional bits). KP defaults to the Q3.10 constant 1710/1024.
- R4: On every update the accumulator becomes the old accumulator plus KI·e, clamped to [-2^19, 2^19-1] in Q4.19 units. The sum uses the new accumulator value. KI defaults to 236/1024.
- R5: The derivative term is KD·(e − e_prev) saturated to 23-bit signed range, where e_prev is the error captured at the previous tick. A change of `err_in` without a tick has no effect on the output or on the stored samples. KD defaults to 2458/1024.
- R6: The sum P+I+D is clamped to [-2048·256, 2047·256] in Q4.19 units and truncated toward minus infinity by dropping its 8 lowest bits. This gives the 12-bit Q1.11 `ctrl_out` (bit 11 is the sign and 11 fractional bits).
- R7: Sustained large errors of either sign drive `ctrl_out` to its limits, 2047 or -2048. When the error returns to zero, the output follows the clamped accumulator with no extra windup lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Update enable, one cycle per switching period |
| err_in | input | 10 | Signed Q1.9 error sample, read when tick is high |
| ctrl_out | output | 12 | Signed Q1.11 control word |

## Verification
The assertions assume that `tick` is never high on two consecutive cycles. If that ever happened, the output-hold property and the previous-error tracking would not be well defined. The stimulus raises `tick` for one cycle and then idles for at least three cycles. Between ticks, `err_in` is moved freely so that the ignore rule is exercised. Error values cover the whole 10-bit range, including -512 and 511, so that both clamp stages are reached in both directions.

// File: rtl/pid_comp.sv
module pid_comp #(
  parameter int EW = 10,
  parameter int GW = 13,
  parameter int OW = 12,
  parameter int EFRAC = 9,
  parameter int GFRAC = 10,
  parameter int OFRAC = 11,
  parameter logic signed [GW-1:0] KP = 13'sb001_1010101110,
  parameter logic signed [GW-1:0] KI = 13'sb000_0011101100,
  parameter logic signed [GW-1:0] KD = 13'sb010_0110011010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [EW-1:0] err_in,
  output logic signed [OW-1:0] ctrl_out
);
  localparam int PW = EW + GW;
  localparam int PFRAC = EFRAC + GFRAC;
  localparam int SH = PFRAC - OFRAC;
  localparam int SW = PW + 2;
  localparam logic signed [PW:0] IMAX = (PW+1)'((1 <<< PFRAC) - 1);
  localparam logic signed [PW:0] IMIN = -(PW+1)'(1 <<< PFRAC);
  localparam logic signed [PW:0] DMAX = (PW+1)'((1 <<< (PW-1)) - 1);
  localparam logic signed [PW:0] DMIN = -(PW+1)'(1 <<< (PW-1));
  localparam logic signed [SW-1:0] OMAX = SW'(((1 <<< (OW-1)) - 1) <<< SH);
  localparam logic signed [SW-1:0] OMIN = -SW'((1 <<< (OW-1)) <<< SH);

  logic signed [EW-1:0] e_cur, e_prev;
  logic                 tick_d;
  logic signed [PW-1:0] integ, i_next, d_t;
  logic signed [SW-1:0] sum_c;

  wire signed [EW:0]   de     = (EW+1)'(e_cur) - (EW+1)'(e_prev);
  wire signed [PW-1:0] p_t    = PW'(e_cur) * PW'(KP);
  wire signed [PW-1:0] i_inc  = PW'(e_cur) * PW'(KI);
  wire signed [PW:0]   d_full = (PW+1)'(de) * (PW+1)'(KD);
  wire signed [PW:0]   i_sum  = (PW+1)'(integ) + (PW+1)'(i_inc);
  wire signed [SW-1:0] sum_r  = SW'(p_t) + SW'(i_next) + SW'(d_t);

  always_comb begin
    if (i_sum > IMAX)      i_next = PW'(IMAX);
    else if (i_sum < IMIN) i_next = PW'(IMIN);
    else                   i_next = PW'(i_sum);
    if (d_full > DMAX)      d_t = PW'(DMAX);
    else if (d_full < DMIN) d_t = PW'(DMIN);
    else                    d_t = PW'(d_full);
    if (sum_r > OMAX)      sum_c = OMAX;
    else if (sum_r < OMIN) sum_c = OMIN;
    else                   sum_c = sum_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cur  <= '0;
      e_prev <= '0;
      tick_d <= 1'b0;
    end else begin
      tick_d <= tick;
      if (tick) begin
        e_prev <= e_cur;
        e_cur  <= err_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ    <= '0;
      ctrl_out <= '0;
    end else if (tick_d) begin
      integ    <= i_next;
      ctrl_out <= sum_c[SH +: OW];
    end
  end
endmodule

module pid_comp_chk #(
  parameter int EW = 10,
  parameter int PW = 23,
  parameter int OW = 12,
  parameter int PFRAC = 19
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 tick_d,
  input logic signed [EW-1:0] e_cur,
  input logic signed [EW-1:0] e_prev,
  input logic signed [PW-1:0] integ,
  input logic signed [OW-1:0] ctrl_out
);
  localparam logic signed [PW-1:0] IMAX = PW'((1 <<< PFRAC) - 1);
  localparam logic signed [PW-1:0] IMIN = -PW'(1 <<< PFRAC);

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> ctrl_out == '0); // R1
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) !tick_d |=> $stable(ctrl_out)); // R2
  AST_INT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (integ <= IMAX) && (integ >= IMIN)); // R4
  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n) tick |=> e_prev == $past(e_cur)); // R5
  AST_NO_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(e_cur) && $stable(e_prev)); // R5
endmodule

bind pid_comp pid_comp_chk #(.EW(EW), .PW(PW), .OW(OW), .PFRAC(PFRAC)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tick_d(tick_d),
  .e_cur(e_cur), .e_prev(e_prev), .integ(integ), .ctrl_out(ctrl_out)
);

// File: tb/test_pid_comp.sv
module test_pid_comp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic signed [9:0]  err_in = '0;
  logic signed [11:0] ctrl_out;

  int checks = 0, errors = 0;
  int q[$];
  int last_exp = 0;
  int m_prev = 0, m_acc = 0;
  logic tb_d = 1'b0, tb_d2 = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pid_comp i_pid_comp (.clk(clk), .rst_n(rst_n), .tick(tick), .err_in(err_in), .ctrl_out(ctrl_out));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin tb_d <= 1'b0; tb_d2 <= 1'b0; end
    else begin tb_d <= tick; tb_d2 <= tb_d; end

  function automatic int clampi(int v, int lo, int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  // R3 R4 R5 R6 reference arithmetic
  function automatic int model(int e);
    int p, d, s;
    p = 1710 * e;
    m_acc = clampi(m_acc + 236 * e, -524288, 524287);
    d = clampi(2458 * (e - m_prev), -4194304, 4194303);
    s = clampi(p + m_acc + d, -2048 * 256, 2047 * 256);
    m_prev = e;
    return s >>> 8;
  endfunction

  task automatic do_tick(int e);
    @(negedge clk);
    err_in = 10'(e);
    tick = 1'b1;
    q.push_back(model(e));
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wiggle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      err_in = 10'((i * 173 + 91) % 1024 - 512);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    m_prev = 0;
    m_acc = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (ctrl_out !== 12'sd0) begin
      errors++;
      $display("FAIL R1 reset output: got %0d expected 0", ctrl_out);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst_n) last_exp = 0;
    else if (tb_d2) begin
      int exp_v;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 update without expected item: got %0d expected none", ctrl_out);
      end else begin
        exp_v = q.pop_front();
        if (int'(ctrl_out) != exp_v) begin
          errors++;
          $display("FAIL R3-6 update value: got %0d expected %0d", ctrl_out, exp_v);
        end
        last_exp = exp_v;
      end
    end else begin
      checks++;
      if (int'(ctrl_out) != last_exp) begin
        errors++;
        $display("FAIL R2 hold between ticks: got %0d expected %0d", ctrl_out, last_exp);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    do_reset();                               // R1
    do_tick(0); do_tick(0);                   // R3 zero error
    do_tick(100); do_tick(100); do_tick(-100); // R3 R5 derivative sign
    wiggle(6);                                // R5 ignored between ticks
    do_tick(37);
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin        // R3 R4 R5 mixed patterns
      lf = ((lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      do_tick((lf % 1024) - 512);
      if (i % 7 == 0) wiggle(3);
    end
    for (int i = 0; i < 10; i++) do_tick(511);  // R7 R4 positive saturation
    do_tick(0); do_tick(0);                      // R7 recovery from clamped integral
    for (int i = 0; i < 12; i++) do_tick(-512); // R7 R4 negative saturation
    do_tick(-1); do_tick(0);                     // R6 floor rounding
    do_reset();                                  // R1 state cleared
    do_tick(50);                                 // R1 prev and integral zero
    wiggle(4);
    do_tick(50);                                 // R5
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule